// File: doc/BRIEF.md
# Two-Drive Register Bus Joiner

This block places two disk-drive register models, a master drive (slot 0) and a slave drive (slot 1), behind a single host register bus. Each slot has a presence strap. A host write reaches every fitted drive in the same cycle, so both drives always hold the same task-file contents. A host read is answered by exactly one drive. The choice depends on the presence straps and, when both drives are fitted, on the drive-select bit held in the slave's drive/head register. The read result is registered and appears one cycle after the strobe.

The block also wires the reset-time handshake between the drives. During a hardware reset with both drives fitted, the slave announces itself on its presence-announce line (DASP). After the reset it signals diagnostics done on its pass line (PDIAG). The master watches both lines. A lone drive, in either slot, acts as the logical master: nothing is chained to it and it does not announce. The slave takes drive number 1 only when a master is fitted; otherwise it answers as drive 0. The drive model included here is a behavioural stand-in that keeps a small register bank, reports busy during hardware reset and records what it saw from its peer.

Top module: `dual_ata_bus`

## Requirements
- R1: A write (wr_en high) stores wr_data at addr in every fitted drive in the same cycle. With both fitted, the value can be read back from either drive.
- R2: With both drives fitted, a read is answered by slot 1 when bit 4 of the drive/head register (address 6) of slot 1 is set, and by slot 0 otherwise.
- R3: With one drive fitted, that drive answers every read, whatever the drive-select bit holds.
- R4: With no drive fitted, a read returns zero and bus_err pulses one cycle after the strobe. A write is dropped and also pulses bus_err. bus_err stays low whenever a drive is fitted.
- R5: rd_valid and rd_data are updated on the first rising edge after rd_en. rd_valid stays low in cycles that follow no read.
- R6: With both drives fitted, after a hardware reset (dev_hw_rst high then low) the error register (address 1) of slot 0 reads 0x0003: bit 0 means the peer's DASP was seen, bit 1 means the peer's PDIAG was seen.
- R7: With a single drive fitted, its error register reads 0x0000 after a hardware reset, because its peer inputs are tied negated.
- R8: The status register (address 7) reads 0x0050 when the answering drive is idle and the drive-select bit equals its drive number, and reads 0x0000 otherwise. Slot 1 has drive number 1 only when slot 0 is fitted, and drive number 0 otherwise.
- R9: The presence straps are sampled only while rst_n is low. Changing them later has no effect on read routing.
- R10: While dev_hw_rst is high, the selected drive's status register reads 0x0080 (busy).
- R11: dasp_host rises during a hardware reset only when both drives are fitted (slot 1 announces). pdiag_host is high once the reset has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dev0_present | input | 1 | Slot 0 presence strap, sampled in reset |
| dev1_present | input | 1 | Slot 1 presence strap, sampled in reset |
| dev_hw_rst | input | 1 | Drive hardware reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| bus_err | output | 1 | Access with no drive fitted |
| dasp_host | output | 1 | Presence-announce line toward the host |
| pdiag_host | output | 1 | Diagnostics-done line toward the host |

## Verification
The bench builds the block with its defaults: 16-bit data and a 3-bit address. Every special slot is therefore reachable: data at 0, error at 1, drive/head at 6 and status at 7. A full 16-bit pattern shows that no data bits are lost in the broadcast or the return path. The bench walks all four presence combinations through a reset. In each one it replays the same accesses, so the routing, the drive-number rule and the handshake chaining produce different expected values across the cases.

// File: rtl/ata_pair_pkg.sv
package ata_pair_pkg;
  localparam int DATA_W_DEF = 16;
  localparam int ADDR_W_DEF = 3;
  localparam int NDEV       = 2;
  localparam int REG_ERR    = 1;   // read: peer-seen flags
  localparam int REG_DH     = 6;   // drive/head, select bit decoded by the joiner
  localparam int REG_STAT   = 7;   // read: status
  localparam int SEL_BIT    = 4;
  localparam logic [7:0] STAT_IDLE = 8'h50;
  localparam logic [7:0] STAT_BUSY = 8'h80;
endpackage

// File: rtl/ata_dev_stub.sv
module ata_dev_stub
  import ata_pair_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF,
  parameter int ADDR_W = ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_id,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hw_rst,
  input  logic              dasp_en,
  input  logic              pdiag_i,
  input  logic              dasp_i,
  output logic              pdiag_o,
  output logic              dasp_o,
  output logic              dev_sel,
  output logic [DATA_W-1:0] rdata
);
  localparam int NREG = 1 << ADDR_W;

  logic [DATA_W-1:0] bank_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_bank
    logic we;
    assign we = wr_en && (addr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  bank_q[g] <= '0;
      else if (we) bank_q[g] <= wr_data;
    end
  end

  logic hw_q, dasp_q, pdiag_q, seen_dasp_q, seen_pdiag_q;
  logic dasp_d, pdiag_d, seen_dasp_d, seen_pdiag_d;

  always_comb begin
    dasp_d  = hw_rst && dasp_en;
    pdiag_d = !hw_rst;
    if (hw_rst && !hw_q) begin
      seen_dasp_d  = 1'b0;
      seen_pdiag_d = 1'b0;
    end else begin
      seen_dasp_d  = seen_dasp_q  | dasp_i;
      seen_pdiag_d = seen_pdiag_q | pdiag_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_q         <= 1'b0;
      dasp_q       <= 1'b0;
      pdiag_q      <= 1'b0;
      seen_dasp_q  <= 1'b0;
      seen_pdiag_q <= 1'b0;
    end else begin
      hw_q         <= hw_rst;
      dasp_q       <= dasp_d;
      pdiag_q      <= pdiag_d;
      seen_dasp_q  <= seen_dasp_d;
      seen_pdiag_q <= seen_pdiag_d;
    end
  end

  assign pdiag_o = pdiag_q;
  assign dasp_o  = dasp_q;
  assign dev_sel = bank_q[REG_DH][SEL_BIT];

  always_comb begin
    rdata = bank_q[addr];
    if (addr == ADDR_W'(REG_ERR))
      rdata = {{(DATA_W-2){1'b0}}, seen_pdiag_q, seen_dasp_q};
    else if (addr == ADDR_W'(REG_STAT))
      rdata = (dev_sel == dev_id) ? DATA_W'(hw_q ? STAT_BUSY : STAT_IDLE) : '0;
  end

  // DASP may only be driven as a consequence of a hardware reset.
  assert_dasp_in_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dasp_o |-> $past(hw_rst));
endmodule

// File: rtl/ata_link_route.sv
module ata_link_route
  import ata_pair_pkg::*;
(
  input  logic [NDEV-1:0] pres,
  input  logic [NDEV-1:0] pdiag_out,
  input  logic [NDEV-1:0] dasp_out,
  output logic [NDEV-1:0] pdiag_in,
  output logic [NDEV-1:0] dasp_in,
  output logic [NDEV-1:0] dasp_en,
  output logic [NDEV-1:0] dev_id,
  output logic            pdiag_host,
  output logic            dasp_host
);
  logic both;
  assign both = &pres;

  always_comb begin
    pdiag_in = '0;
    dasp_in  = '0;
    dasp_en  = '0;
    dev_id   = '0;
    if (both) begin
      pdiag_in[0] = pdiag_out[1];
      dasp_in[0]  = dasp_out[1];
      dasp_en[1]  = 1'b1;
    end
    dev_id[1] = pres[0];
  end

  assign pdiag_host = |(pdiag_out & pres);
  assign dasp_host  = |(dasp_out & pres);
endmodule

// File: rtl/ata_rd_select.sv
module ata_rd_select
  import ata_pair_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [NDEV-1:0]   pres,
  input  logic              dev1_sel,
  input  logic [DATA_W-1:0] rdata0,
  input  logic [DATA_W-1:0] rdata1,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              bus_err
);
  logic [DATA_W-1:0] data_d, data_q;
  logic              err_d, err_q, valid_q;

  always_comb begin
    unique case (pres)
      2'b11:   data_d = dev1_sel ? rdata1 : rdata0;
      2'b10:   data_d = rdata1;
      2'b01:   data_d = rdata0;
      default: data_d = '0;
    endcase
    err_d = (rd_en || wr_en) && (pres == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (rd_en) data_q <= data_d;
      valid_q <= rd_en;
      err_q   <= err_d;
    end
  end

  assign rd_data  = data_q;
  assign rd_valid = valid_q;
  assign bus_err  = err_q;

  assert_rd_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_no_stray_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  assert_empty_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && pres == '0) |=> (rd_data == '0 && bus_err));
  assert_slave_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && pres == 2'b11 && dev1_sel) |=> (rd_data == $past(rdata1)));
endmodule

// File: rtl/dual_ata_bus.sv
module dual_ata_bus
  import ata_pair_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF,
  parameter int ADDR_W = ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev0_present,
  input  logic              dev1_present,
  input  logic              dev_hw_rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              bus_err,
  output logic              dasp_host,
  output logic              pdiag_host
);
  logic [NDEV-1:0] pres_q;

  // Straps load on every edge while reset is held, then freeze.
  always_ff @(posedge clk) begin
    if (!rst_n) pres_q <= {dev1_present, dev0_present};
  end

  logic [NDEV-1:0] pdiag_out, dasp_out, pdiag_in, dasp_in, dasp_en, dev_id, sel;
  logic [DATA_W-1:0] dev_rdata [NDEV];

  ata_link_route u_route (
    .pres      (pres_q),
    .pdiag_out (pdiag_out),
    .dasp_out  (dasp_out),
    .pdiag_in  (pdiag_in),
    .dasp_in   (dasp_in),
    .dasp_en   (dasp_en),
    .dev_id    (dev_id),
    .pdiag_host(pdiag_host),
    .dasp_host (dasp_host)
  );

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    logic dev_we;
    assign dev_we = wr_en && pres_q[d];
    ata_dev_stub #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dev (
      .clk    (clk),
      .rst_n  (rst_n),
      .dev_id (dev_id[d]),
      .wr_en  (dev_we),
      .addr   (addr),
      .wr_data(wr_data),
      .hw_rst (dev_hw_rst),
      .dasp_en(dasp_en[d]),
      .pdiag_i(pdiag_in[d]),
      .dasp_i (dasp_in[d]),
      .pdiag_o(pdiag_out[d]),
      .dasp_o (dasp_out[d]),
      .dev_sel(sel[d]),
      .rdata  (dev_rdata[d])
    );
  end

  ata_rd_select #(.DATA_W(DATA_W)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .pres    (pres_q),
    .dev1_sel(sel[1]),
    .rdata0  (dev_rdata[0]),
    .rdata1  (dev_rdata[1]),
    .rd_data (rd_data),
    .rd_valid(rd_valid),
    .bus_err (bus_err)
  );

  assert_straps_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(pres_q));
  assert_err_only_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pres_q != '0) |=> !bus_err);
endmodule

// File: tb/tb_dual_ata_bus.sv
module tb_dual_ata_bus;
  localparam int DW = 16;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n, p0, p1, hwr, we, re;
  logic [AW-1:0] a;
  logic [DW-1:0] wd, rd;
  logic rv, err, dasp_h, pdiag_h;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int         exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  dual_ata_bus #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .dev0_present(p0), .dev1_present(p1),
    .dev_hw_rst(hwr), .wr_en(we), .rd_en(re), .addr(a), .wr_data(wd),
    .rd_data(rd), .rd_valid(rv), .bus_err(err),
    .dasp_host(dasp_h), .pdiag_host(pdiag_h)
  );

  task automatic chk(input int act, input int expv, input string tag);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  // Monitor: compare each returned read with the oldest expectation.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && rv === 1'b1) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R5: unexpected rd_valid, data 0x%0h expected none", rd);
      end else begin
        chk(int'(rd), exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic wr(input int ad, input int v);
    @(negedge clk); we = 1'b1; a = AW'(ad); wd = DW'(v);
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rdx(input int ad, input int expv, input string tag);
    exp_q.push_back(expv); tag_q.push_back(tag);
    @(negedge clk); re = 1'b1; a = AW'(ad);
    @(negedge clk); re = 1'b0;
  endtask

  task automatic boot(input logic s0, input logic s1);
    @(negedge clk); rst_n = 1'b0; p0 = s0; p1 = s1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic hw_pulse(input int dasp_exp, input int busy_stat, input string tag);
    @(negedge clk); hwr = 1'b1;
    repeat (2) @(negedge clk);
    chk(int'(dasp_h), dasp_exp, {tag, " R11 dasp_host in reset"});
    rdx(7, busy_stat, {tag, " R10 busy status"});
    @(negedge clk); hwr = 1'b0;
    repeat (4) @(negedge clk);
    chk(int'(pdiag_h), 1, {tag, " R11 pdiag_host after reset"});
  endtask

  initial begin
    rst_n = 1'b0; p0 = 1'b0; p1 = 1'b0; hwr = 1'b0; we = 1'b0; re = 1'b0;
    a = '0; wd = '0;

    // Both drives fitted
    boot(1'b1, 1'b1);
    chk(int'(rv), 0, "R5 reset state rd_valid");
    chk(int'(err), 0, "R4 reset state bus_err");
    hw_pulse(1, 16'h0080, "both");
    rdx(1, 16'h0003, "R6 master saw slave DASP and PDIAG");
    rdx(7, 16'h0050, "R8 master idle status");
    wr(2, 16'hA5C3);
    rdx(2, 16'hA5C3, "R1 broadcast seen by master");
    wr(6, 16'h0010);
    rdx(2, 16'hA5C3, "R1 broadcast seen by slave");
    rdx(1, 16'h0000, "R2 slave answers with its own error reg");
    rdx(7, 16'h0050, "R8 slave has drive number 1");
    @(negedge clk); p1 = 1'b0;
    rdx(1, 16'h0000, "R9 strap change after reset ignored");
    chk(int'(err), 0, "R4 no error with drives fitted");
    wr(6, 16'h0000);
    rdx(6, 16'h0000, "R2 select cleared routes to master");
    rdx(1, 16'h0003, "R2 master answers");

    // Master only
    boot(1'b1, 1'b0);
    hw_pulse(0, 16'h0080, "master only");
    rdx(1, 16'h0000, "R7 lone master peer flags clear");
    wr(6, 16'h0010);
    rdx(6, 16'h0010, "R3 lone master answers despite select");
    rdx(7, 16'h0000, "R8 status blank when select mismatches");

    // Slave only
    boot(1'b0, 1'b1);
    hw_pulse(0, 16'h0080, "slave only");
    rdx(1, 16'h0000, "R7 lone slave peer flags clear");
    rdx(7, 16'h0050, "R8 lone slave takes drive number 0");
    wr(6, 16'h0010);
    rdx(6, 16'h0010, "R3 lone slave answers despite select");
    rdx(7, 16'h0000, "R8 lone slave not drive 1");

    // No drive
    boot(1'b0, 1'b0);
    wr(2, 16'h1234);
    chk(int'(err), 1, "R4 write with no drive flags error");
    rdx(2, 16'h0000, "R4 read with no drive returns zero");
    chk(int'(err), 1, "R4 read with no drive flags error");
    @(negedge clk);
    chk(int'(err), 0, "R4 error is a single pulse");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R5: %0d reads never returned, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule